// File: doc/BRIEF.md
# Latched Status and Converter Snapshot Read Page

This block is the read-only register page of a serially configured driver. It occupies sixteen byte addresses. Two status bytes collect event flags. A flag is set by a one-cycle event pulse and stays set until software reads the byte that holds it. Two 10-bit converter results are each split across two bytes. The block also drives an active-low alert line from the status flags. The alert can feed an interrupt input, and a per-bit mask selects which flags it reports.

The serial front end uses a simple register bus: a read strobe, a 4-bit address, registered read data and a burst flag that stays high through an auto-increment sequence. A 10-bit value can change between its two byte reads. To prevent that, the block copies both converter results into a shadow on the first cycle of a burst. Every read in the rest of that burst is served from the shadow. Conversions that arrive during the burst still update the live copy, which single reads outside a burst return.

Top module: `status_snapshot_page`

## Requirements
- R1: Read data appears on rd_data_o one cycle after a cycle with rd_en_i high and holds between reads. Address 0x0 returns status byte 0 and 0x1 returns status byte 1. Addresses 0x3 and 0x4 return converter 1, and 0x5 and 0x6 return converter 2.
- R2: A set status bit stays set until its byte is read. That read returns the set value, and the bit reads 0 afterwards unless a new event sets it again.
- R3: A high bit on evt0_i or evt1_i sets the matching status bit on the next clock edge. Bit 0 of status byte 0 is the storage-initialised flag, driven by evt0_i[0].
- R4: An event that arrives in the same cycle as the clearing read of its byte leaves the bit set after that read.
- R5: Byte layout of a converter value: the lower address of the pair returns bits 9:8 in bits 1:0 and zeros above them. The higher address returns bits 7:0.
- R6: In the first cycle of burst_i high, both converter results are copied into a shadow. Every later read in that burst returns shadow bytes, even if samples arrive during the burst. A new burst takes a new copy.
- R7: A converter's live value loads from its sample input when its valid strobe is high. Reads with burst_i low, and the first read of a burst, return live values.
- R8: alert_no is low exactly when some status bit is set and its mask bit is 0. mask_i bit i covers status byte 0 bit i, and bit 8+i covers status byte 1 bit i. Masking never clears a flag.
- R9: Reads of addresses 0x2 and 0x7 to 0xF return 0x00 and clear no status bit.
- R10: After reset, all status bits, live values, shadows and rd_data_o are 0, and alert_no is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_en_i | input | 1 | Read strobe |
| rd_addr_i | input | 4 | Read address within the page |
| burst_i | input | 1 | High through an auto-increment read sequence |
| evt0_i | input | 8 | Event pulses for status byte 0 |
| evt1_i | input | 8 | Event pulses for status byte 1 |
| adc1_i | input | 10 | Converter 1 sample |
| adc1_vld_i | input | 1 | Converter 1 sample valid |
| adc2_i | input | 10 | Converter 2 sample |
| adc2_vld_i | input | 1 | Converter 2 sample valid |
| mask_i | input | 16 | Alert mask, 1 hides a flag |
| rd_data_o | output | 8 | Registered read data |
| alert_no | output | 1 | Alert, active low |

## Verification
Some behaviours are checked by assertions on every cycle:
- events setting flags, including the same-cycle clear race;
- flags holding until they are read;
- the shadow loading only at burst start and staying frozen otherwise;
- reads of unused addresses returning zero;
- the alert following unmasked events.

Other behaviours only the bench scenarios can show. These are the byte layout of each converter pair, and that a whole burst returns one coherent sample while new samples arrive. They also include that single reads then return the newer live values, and that masking hides a flag without erasing it.

// File: rtl/ro_page_pkg.sv
package ro_page_pkg;
  localparam int unsigned ADR_STS0     = 0;
  localparam int unsigned ADR_STS1     = 1;
  localparam int unsigned ADR_ADC_BASE = 3;  // pair k at BASE+2k (high bits), BASE+2k+1 (low byte)
endpackage

// File: rtl/sticky_status.sv
module sticky_status #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] evt_i,
  input  logic         clr_i,
  output logic [W-1:0] sts_o
);
  logic [W-1:0] sts_q;

  // event wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sts_q <= '0;
    else         sts_q <= (sts_q & ~{W{clr_i}}) | evt_i;
  end

  assign sts_o = sts_q;

  assert_evt_set_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|evt_i) |=> ((sts_q & $past(evt_i)) == $past(evt_i)));

  assert_race_keep_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && |evt_i) |=> (sts_q == $past(evt_i)));

  assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> ((sts_q & $past(sts_q)) == $past(sts_q)));

  assert_clear_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !(|evt_i)) |=> (sts_q == '0));
endmodule

// File: rtl/adc_snapshot.sv
module adc_snapshot #(
  parameter int unsigned W = 10
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] smp_i,
  input  logic         vld_i,
  input  logic         cap_i,
  output logic [W-1:0] live_o,
  output logic [W-1:0] shadow_o
);
  logic [W-1:0] live_q, shadow_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    live_q <= '0;
    else if (vld_i) live_q <= smp_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    shadow_q <= '0;
    else if (cap_i) shadow_q <= live_q;
  end

  assign live_o   = live_q;
  assign shadow_o = shadow_q;

  assert_capture_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_i |=> (shadow_q == $past(live_q)));

  assert_frozen_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_i |=> $stable(shadow_q));

  assert_live_load_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_i |=> (live_q == $past(smp_i)));
endmodule

// File: rtl/page_read_mux.sv
module page_read_mux
  import ro_page_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADC_W  = 10,
  parameter int unsigned N_ADC  = 2
) (
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic [DATA_W-1:0]             sts0_i,
  input  logic [DATA_W-1:0]             sts1_i,
  input  logic [N_ADC-1:0][ADC_W-1:0]   adc_i,
  output logic [DATA_W-1:0]             data_o
);
  localparam int unsigned HI_W = ADC_W - DATA_W;

  always_comb begin
    data_o = '0;
    if (addr_i == ADDR_W'(ADR_STS0)) data_o = sts0_i;
    if (addr_i == ADDR_W'(ADR_STS1)) data_o = sts1_i;
    for (int k = 0; k < N_ADC; k++) begin
      if (addr_i == ADDR_W'(ADR_ADC_BASE + 2*k))
        data_o = {{(DATA_W-HI_W){1'b0}}, adc_i[k][ADC_W-1:DATA_W]};
      if (addr_i == ADDR_W'(ADR_ADC_BASE + 2*k + 1))
        data_o = adc_i[k][DATA_W-1:0];
    end
  end
endmodule

// File: rtl/status_snapshot_page.sv
module status_snapshot_page
  import ro_page_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADC_W  = 10
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                rd_en_i,
  input  logic [ADDR_W-1:0]   rd_addr_i,
  input  logic                burst_i,
  input  logic [DATA_W-1:0]   evt0_i,
  input  logic [DATA_W-1:0]   evt1_i,
  input  logic [ADC_W-1:0]    adc1_i,
  input  logic                adc1_vld_i,
  input  logic [ADC_W-1:0]    adc2_i,
  input  logic                adc2_vld_i,
  input  logic [2*DATA_W-1:0] mask_i,
  output logic [DATA_W-1:0]   rd_data_o,
  output logic                alert_no
);
  localparam int unsigned N_ADC  = 2;
  localparam int unsigned ADC_HI = ADR_ADC_BASE + 2*N_ADC - 1;

  logic [DATA_W-1:0]           sts0, sts1, mux_data, rd_data_q;
  logic [N_ADC-1:0][ADC_W-1:0] smp, live, shadow, src;
  logic [N_ADC-1:0]            vld;
  logic                        burst_q, cap, clr0, clr1;

  assign smp = {adc2_i, adc1_i};
  assign vld = {adc2_vld_i, adc1_vld_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) burst_q <= 1'b0;
    else         burst_q <= burst_i;
  end

  assign cap  = burst_i & ~burst_q;
  assign clr0 = rd_en_i && (rd_addr_i == ADDR_W'(ADR_STS0));
  assign clr1 = rd_en_i && (rd_addr_i == ADDR_W'(ADR_STS1));

  sticky_status #(.W(DATA_W)) u_sts0 (
    .clk_i, .rst_ni, .evt_i(evt0_i), .clr_i(clr0), .sts_o(sts0));
  sticky_status #(.W(DATA_W)) u_sts1 (
    .clk_i, .rst_ni, .evt_i(evt1_i), .clr_i(clr1), .sts_o(sts1));

  for (genvar k = 0; k < N_ADC; k++) begin : g_adc
    adc_snapshot #(.W(ADC_W)) u_snap (
      .clk_i, .rst_ni, .smp_i(smp[k]), .vld_i(vld[k]), .cap_i(cap),
      .live_o(live[k]), .shadow_o(shadow[k]));
    // first burst cycle reads live: it equals what the shadow captures
    assign src[k] = (burst_i && burst_q) ? shadow[k] : live[k];
  end

  page_read_mux #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ADC_W(ADC_W), .N_ADC(N_ADC)
  ) u_mux (
    .addr_i(rd_addr_i), .sts0_i(sts0), .sts1_i(sts1), .adc_i(src), .data_o(mux_data));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rd_data_q <= '0;
    else if (rd_en_i) rd_data_q <= mux_data;
  end

  assign rd_data_o = rd_data_q;
  assign alert_no  = ~|({sts1, sts0} & ~mask_i);

  assert_unused_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && (rd_addr_i == ADDR_W'(2) || rd_addr_i > ADDR_W'(ADC_HI)))
      |=> (rd_data_o == '0));

  assert_rd_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rd_data_o));

  assert_alert_evt_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|({evt1_i, evt0_i} & ~mask_i)) |=> (!$stable(mask_i) || !alert_no));
endmodule

// File: tb/sim_status_snapshot_page.sv
module sim_status_snapshot_page;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd_en = 1'b0, burst = 1'b0;
  logic [3:0]  addr = '0;
  logic [7:0]  evt0 = '0, evt1 = '0;
  logic [9:0]  a1 = '0, a2 = '0;
  logic        a1v = 1'b0, a2v = 1'b0;
  logic [15:0] mask = '0;
  logic [7:0]  rdata;
  logic        alert_n;

  int checks = 0, errors = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2 clk = ~clk;

  status_snapshot_page u0 (
    .clk_i(clk), .rst_ni(rst_n), .rd_en_i(rd_en), .rd_addr_i(addr), .burst_i(burst),
    .evt0_i(evt0), .evt1_i(evt1), .adc1_i(a1), .adc1_vld_i(a1v), .adc2_i(a2),
    .adc2_vld_i(a2v), .mask_i(mask), .rd_data_o(rdata), .alert_no(alert_n));

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // monitor: read issued at a posedge returns data just after it
  initial forever begin
    logic issued;
    @(posedge clk);
    issued = rd_en;
    #1;
    if (issued) begin
      if (exp_q.size() == 0) chk(rdata, 8'hxx, "unexpected read");
      else chk(rdata, exp_q.pop_front(), tag_q.pop_front());
    end
  end

  task automatic tick();
    @(negedge clk);
    rd_en = 0; evt0 = 0; evt1 = 0; a1v = 0; a2v = 0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [7:0] e, input string tag);
    rd_en = 1; addr = a;
    exp_q.push_back(e); tag_q.push_back(tag);
  endtask

  initial begin
    #800000;
    errors++; checks++;
    $display("FAIL watchdog act=hung exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(rdata, 8'h00, "R10 rdata");
    chk({7'd0, alert_n}, 8'h01, "R10 alert");
    rst_n = 1;
    tick(); rd(4'h0, 8'h00, "R10 sts0");
    tick(); rd(4'h4, 8'h00, "R10 adc1 lo");
    tick(); rd(4'h6, 8'h00, "R10 adc2 lo");

    // init flag, sticky, clear on read
    tick(); evt0 = 8'h01;
    tick(); evt0 = 8'h00;
    tick(); rd(4'h0, 8'h01, "R3 init flag");
    tick(); rd(4'h0, 8'h00, "R2 cleared");

    // mask hides but keeps
    tick(); mask = 16'hFFFF; evt1 = 8'hA5;
    tick();
    chk({7'd0, alert_n}, 8'h01, "R8 masked");
    mask = 16'hFEFF; #1;
    chk({7'd0, alert_n}, 8'h00, "R8 unmasked");
    tick(); rd(4'h1, 8'hA5, "R2 sts1");
    tick(); tick();
    chk({7'd0, alert_n}, 8'h01, "R2 alert after clear");
    mask = 16'h0000;

    // same-cycle event and clear
    tick(); evt0 = 8'h02;
    tick(); rd(4'h0, 8'h02, "R4 first read"); evt0 = 8'h04;
    tick(); rd(4'h0, 8'h04, "R4 kept");
    tick(); rd(4'h0, 8'h00, "R4 then clear");

    // unused addresses
    tick(); evt0 = 8'h10;
    tick(); rd(4'h2, 8'h00, "R9 0x2");
    tick(); rd(4'h7, 8'h00, "R9 0x7");
    tick(); rd(4'hF, 8'h00, "R9 0xF");
    tick(); rd(4'h0, 8'h10, "R9 not cleared");

    // live values and layout
    tick(); a1 = 10'h2B7; a1v = 1; a2 = 10'h15A; a2v = 1;
    tick(); rd(4'h3, 8'h02, "R5 adc1 hi");
    tick(); rd(4'h4, 8'hB7, "R5 adc1 lo");
    tick(); rd(4'h5, 8'h01, "R5 adc2 hi");
    tick(); rd(4'h6, 8'h5A, "R7 adc2 lo");

    // burst coherence
    tick(); burst = 1; rd(4'h3, 8'h02, "R6 burst hi");
    tick(); rd(4'h4, 8'hB7, "R6 burst lo"); a1 = 10'h155; a1v = 1;
    tick(); rd(4'h5, 8'h01, "R6 burst adc2 hi"); a2 = 10'h0AA; a2v = 1;
    tick(); rd(4'h6, 8'h5A, "R6 burst adc2 lo");
    tick(); rd(4'h3, 8'h02, "R6 still frozen");
    tick(); burst = 0;
    tick(); rd(4'h3, 8'h01, "R7 live after burst");
    tick(); rd(4'h4, 8'h55, "R7 live lo");
    tick(); rd(4'h6, 8'hAA, "R7 adc2 live");
    tick(); burst = 1; rd(4'h4, 8'h55, "R6 new burst");
    tick(); rd(4'h5, 8'h00, "R6 new burst adc2");
    tick(); burst = 0;
    tick(); tick();
    chk(8'(exp_q.size()), 8'h00, "R1 all reads returned");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule